// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a 32-bit physical address by reading a two-level page structure from memory. A caller hands over a linear address through a valid/ready handshake. The walker takes the page directory frame from the base input at that moment. It then issues at most two single-word reads through a request/response memory port. The first read returns the directory entry, which names the frame of a page table. The second read returns the table entry, which names the frame of the page.

The result is either the physical address or a fault. It is held with a valid flag until the caller takes it. Only one walk runs at a time. When a walk faults, its linear address is kept in a fault-address output so that software can read it. A directory entry that is not present ends the walk after a single read.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk goes to base_frame*4096 + 4*d, where d is bits [31:22] of the linear address and base_frame is the value sampled when the request was accepted.
- R2: When the directory entry has bit 0 set, the second read goes to F*4096 + 4*t, where F is bits [31:12] of the directory entry and t is bits [21:12] of the linear address.
- R3: When the table entry has bit 0 set, res_phys equals bits [31:12] of the table entry concatenated with bits [11:0] of the linear address, and res_fault is 0.
- R4: When the directory entry has bit 0 clear, the walk ends with res_fault = 1 after exactly one memory read, and no second read is issued.
- R5: When the directory entry is present but the table entry has bit 0 clear, the walk ends with res_fault = 1 after two reads.
- R6: fault_addr takes the linear address of a walk in the same cycle that the walk's faulting result first appears. It keeps its value at every other time, including across successful walks.
- R7: req_ready is 1 only while no walk is in progress and no result is waiting. A request offered during a walk is not accepted.
- R8: Once res_valid is 1, it stays 1 with res_phys and res_fault unchanged until a cycle where res_ready is 1. It then falls on the next clock.
- R9: A change of base_frame after a request has been accepted does not affect that walk's reads or result.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, the next cycle keeps mem_req_valid at 1 with the same mem_req_addr.
- R11: After reset, req_ready = 1, res_valid = 0, mem_req_valid = 0 and fault_addr = 0.
- R12: With mem_req_ready held at 1 and each response returned in the cycle after its request is taken, res_valid rises 4 clock edges after the accepting edge for a two-read walk and 2 edges after for a one-read walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_frame | input | 20 | Frame number of the current page directory |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read from memory |
| res_valid | output | 1 | Translation result available |
| res_ready | input | 1 | Caller takes the result |
| res_phys | output | 32 | Physical address (0 on a fault) |
| res_fault | output | 1 | Walk ended in a page fault |
| fault_addr | output | 32 | Linear address of the most recent faulting walk |

## Verification
The reference model counts falling edges from the edge where a request is accepted. With a memory that never stalls, it expects the result at the fifth falling edge for a two-read walk and at the third for a walk stopped at the directory. That is the fourth and second rising edge after acceptance. Every read is checked at the cycle its handshake completes, against the address list the model built when it accepted the request. req_ready and fault_addr are compared on every cycle. Hold behaviour on both the memory port and the result port is checked one cycle after each stalled cycle. When the memory stalls, exact latency is not checked; the order of the reads, their count and the held values are checked instead.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [DIR_W+TBL_W-1:0]           base_frame,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [DIR_W+TBL_W+OFF_W-1:0]     req_lin,
  output logic                             mem_req_valid,
  input  logic                             mem_req_ready,
  output logic [DIR_W+TBL_W+OFF_W-1:0]     mem_req_addr,
  input  logic                             mem_rsp_valid,
  input  logic [DIR_W+TBL_W+OFF_W-1:0]     mem_rsp_data,
  output logic                             res_valid,
  input  logic                             res_ready,
  output logic [DIR_W+TBL_W+OFF_W-1:0]     res_phys,
  output logic                             res_fault,
  output logic [DIR_W+TBL_W+OFF_W-1:0]     fault_addr
);
  localparam int ADDR_W = DIR_W + TBL_W + OFF_W;
  localparam int FRAME_W = ADDR_W - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_TREQ, S_TWAIT, S_DONE} st_t;

  st_t                st;
  logic [ADDR_W-1:0]  lin_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] tframe_q;
  logic [ADDR_W-1:0]  phys_q;
  logic               fault_q;
  logic [ADDR_W-1:0]  fault_addr_q;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                   input logic [ADDR_W-1:0] idx);
    return {frame, {OFF_W{1'b0}}} + (idx << 2);
  endfunction

  wire [ADDR_W-1:0] dir_idx = ADDR_W'(lin_q[ADDR_W-1 -: DIR_W]);
  wire [ADDR_W-1:0] tbl_idx = ADDR_W'(lin_q[OFF_W +: TBL_W]);
  wire              present = mem_rsp_data[0];
  wire [FRAME_W-1:0] rsp_frame = mem_rsp_data[ADDR_W-1:OFF_W];

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_DREQ) || (st == S_TREQ);
  assign mem_req_addr  = (st == S_DREQ) ? entry_addr(base_q, dir_idx)
                                        : entry_addr(tframe_q, tbl_idx);
  assign res_valid     = (st == S_DONE);
  assign res_phys      = phys_q;
  assign res_fault     = fault_q;
  assign fault_addr    = fault_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      lin_q        <= '0;
      base_q       <= '0;
      tframe_q     <= '0;
      phys_q       <= '0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q  <= req_lin;
          base_q <= base_frame;
          st     <= S_DREQ;
        end
        S_DREQ: if (mem_req_ready) st <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          if (!present) begin
            fault_q      <= 1'b1;
            phys_q       <= '0;
            fault_addr_q <= lin_q;
            st           <= S_DONE;
          end else begin
            tframe_q <= rsp_frame;
            st       <= S_TREQ;
          end
        end
        S_TREQ: if (mem_req_ready) st <= S_TWAIT;
        S_TWAIT: if (mem_rsp_valid) begin
          if (!present) begin
            fault_q      <= 1'b1;
            phys_q       <= '0;
            fault_addr_q <= lin_q;
          end else begin
            fault_q <= 1'b0;
            phys_q  <= {rsp_frame, lin_q[OFF_W-1:0]};
          end
          st <= S_DONE;
        end
        S_DONE: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_phys) && $stable(res_fault));

  // R6
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> fault_addr == lin_q);

  // R3
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_phys[OFF_W-1:0] == lin_q[OFF_W-1:0]);

  // R7
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R4
  dir_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DWAIT && mem_rsp_valid && !mem_rsp_data[0] |=> res_valid && res_fault && !mem_req_valid);
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [19:0] base_frame = '0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 0;
  logic [31:0] res_phys;
  logic        res_fault;
  logic [31:0] fault_addr;

  pt_walker i_pt_walker (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [logic [31:0]];

  bit stall_mode = 0;
  int res_delay = 0;
  int done_cnt = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model and memory responder, evaluated once per cycle after the falling edge
  initial begin
    bit busy = 0, seen_res = 0, rsp_pend = 0;
    bit prev_mv = 0, prev_mr = 0, prev_rv = 0, prev_rr = 0, prev_fault = 0, exp_fault = 0;
    logic [31:0] rsp_addr = 0, prev_ma = 0, prev_phys = 0, exp_phys = 0, exp_lin = 0, model_fa = 0;
    logic [31:0] exp_addr [2];
    logic [31:0] e1, e2;
    int exp_n = 0, rd_idx = 0, cyc = 0, wcnt = 0, cnt = 0;
    forever begin
      @(negedge clk); #1;
      if (!rst_n) begin
        busy = 0; seen_res = 0; rsp_pend = 0; prev_mv = 0; prev_rv = 0; model_fa = 0;
        mem_rsp_valid = 0; mem_req_ready = 0; res_ready = 0;
        continue;
      end
      mem_rsp_valid = rsp_pend;
      mem_rsp_data  = rsp_pend ? rd(rsp_addr) : 32'h0;
      rsp_pend = 0;
      cnt++;
      mem_req_ready = stall_mode ? (cnt % 3 == 0) : 1'b1;

      chk(req_ready == !busy, "R7 req_ready", 32'(req_ready), 32'(!busy));
      if (prev_mv && !prev_mr)
        chk(mem_req_valid && mem_req_addr == prev_ma, "R10 read held", mem_req_addr, prev_ma);
      if (prev_rv && !prev_rr)
        chk(res_valid && res_phys == prev_phys && res_fault == prev_fault, "R8 result held", res_phys, prev_phys);
      if (busy) cyc++;

      if (mem_req_valid && mem_req_ready) begin
        if (!busy || rd_idx >= exp_n) chk(0, "R4 extra read", mem_req_addr, 32'h0);
        else chk(mem_req_addr == exp_addr[rd_idx], rd_idx == 0 ? "R1 dir read" : "R2 table read",
                 mem_req_addr, exp_addr[rd_idx]);
        rd_idx++;
        rsp_pend = 1;
        rsp_addr = mem_req_addr;
      end

      if (res_valid && !busy) chk(0, "R8 spurious result", 32'(res_valid), 32'h0);
      if (res_valid && busy && !seen_res) begin
        seen_res = 1;
        chk(rd_idx == exp_n, "R4 read count", 32'(rd_idx), 32'(exp_n));
        chk(res_fault == exp_fault, exp_n == 1 ? "R4 dir fault" : "R5 table fault",
            32'(res_fault), 32'(exp_fault));
        if (!exp_fault) chk(res_phys == exp_phys, "R3 phys", res_phys, exp_phys);
        if (!stall_mode) chk(cyc == (exp_n == 2 ? 5 : 3), "R12 latency", 32'(cyc), 32'(exp_n == 2 ? 5 : 3));
        if (exp_fault) model_fa = exp_lin;
      end
      chk(fault_addr == model_fa, "R6 fault_addr", fault_addr, model_fa);

      if (res_valid) begin
        res_ready = (wcnt >= res_delay);
        wcnt++;
      end else res_ready = 0;
      if (res_valid && res_ready) begin
        busy = 0; seen_res = 0; wcnt = 0; done_cnt++;
      end

      if (req_valid && req_ready) begin
        exp_lin = req_lin;
        exp_addr[0] = {base_frame, 12'h0} + {20'h0, req_lin[31:22], 2'b00};
        e1 = rd(exp_addr[0]);
        if (!e1[0]) begin
          exp_n = 1; exp_fault = 1; exp_phys = 0;
        end else begin
          exp_addr[1] = {e1[31:12], 12'h0} + {20'h0, req_lin[21:12], 2'b00};
          e2 = rd(exp_addr[1]);
          exp_n = 2; exp_fault = !e2[0]; exp_phys = {e2[31:12], req_lin[11:0]};
        end
        busy = 1; cyc = 0; rd_idx = 0; wcnt = 0;
      end

      prev_mv = mem_req_valid; prev_mr = mem_req_ready; prev_ma = mem_req_addr;
      prev_rv = res_valid; prev_rr = res_ready; prev_phys = res_phys; prev_fault = res_fault;
    end
  end

  task automatic walk(input logic [31:0] lin, input bit swap_base);
    int d = done_cnt;
    logic [19:0] saved = base_frame;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_lin = lin;
    @(negedge clk);
    req_valid = 0;
    if (swap_base) base_frame = 20'h00050;
    while (done_cnt == d) @(negedge clk);
    base_frame = saved;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // directory at frame 0x00010
    mem[32'h00010000] = 32'h00020001;
    mem[32'h00010004] = 32'h00000000;
    mem[32'h00010008] = 32'h00030001;
    mem[32'h0001000C] = 32'h00040000;
    mem[32'h00020000] = 32'h00001001;
    mem[32'h00020004] = 32'h00000000;
    mem[32'h00020FFC] = 32'h00005001;
    mem[32'h00030000] = 32'h0000A001;
    mem[32'h00030004] = 32'h0000C001;
    mem[32'h00030008] = 32'hABCDE000;
    // second directory at frame 0x00050
    mem[32'h00050000] = 32'h00060001;
    mem[32'h00060000] = 32'h00077001;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R11 reset state
    chk(req_ready == 1, "R11 req_ready", 32'(req_ready), 32'h1);
    chk(res_valid == 0, "R11 res_valid", 32'(res_valid), 32'h0);
    chk(mem_req_valid == 0, "R11 mem_req_valid", 32'(mem_req_valid), 32'h0);
    chk(fault_addr == 0, "R11 fault_addr", fault_addr, 32'h0);

    base_frame = 20'h00010;
    walk(32'h00000001, 0);  // R3
    walk(32'h00001001, 0);  // R5
    walk(32'h003FF001, 0);  // R3, R6 keeps value
    walk(32'h00400000, 0);  // R4
    walk(32'h00801004, 0);  // R2
    walk(32'h00802008, 0);  // R5
    walk(32'h00C00123, 0);  // R4 nonzero frame, not present
    walk(32'hFFFFFFFF, 0);  // R4 top index

    // R9 base changed right after acceptance
    walk(32'h00801008, 1);
    walk(32'h00000ABC, 1);

    base_frame = 20'h00050;
    walk(32'h00000123, 0);  // R1 with other directory
    base_frame = 20'h00010;

    // R7 request held high with changing address during a walk
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    begin
      int d = done_cnt;
      req_valid = 1; req_lin = 32'h00800001;
      @(negedge clk); req_lin = 32'h00400000;
      @(negedge clk); req_valid = 0;
      while (done_cnt == d) @(negedge clk);
    end

    // R8 caller delays taking the result
    res_delay = 3;
    walk(32'h00801FFF, 0);
    walk(32'h00001000, 0);
    res_delay = 0;

    // R10 stalling memory
    stall_mode = 1;
    walk(32'h003FF7FF, 0);
    walk(32'h00802000, 0);
    walk(32'h00400010, 0);
    res_delay = 2;
    walk(32'h00800FFF, 1);
    stall_mode = 0;
    res_delay = 0;

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule